// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block finds the size, in bytes, of each instruction in a byte-aligned fetch buffer. The fetch stage needs that size to know where the next instruction begins. The size depends on nine bits only: the 8-bit opcode byte, plus bit 0 of the byte that follows it. That second bit is the format-byte flag. Those nine bits index a 512-entry table of 3-bit lengths, and a write port lets the table be reloaded. An entry of 0 marks an unrecognised opcode. Such an opcode is reported as one byte long with an illegal flag, so the walk can resume at the next byte.

The walker keeps a byte offset into a buffer of `BUF_BYTES` bytes. The fetch logic presents that buffer together with a count of valid bytes. While `run` is high, the walker decodes the instruction at its offset. If the whole instruction lies inside the valid bytes, it reports the start offset and length and moves to the next instruction on the clock edge. If it does not fit, the walker signals a stall and keeps its offset. A restart input returns the offset to zero.

Top module: `ilen_walker`

## Requirements
- R1: After reset the offset is 0 and the table holds the default contents given in R2 to R6 and R12.
- R2: The table index is {bit 0 of the byte after the opcode, opcode}. For an ordinary opcode, that bit clear gives length 4 and `out_fmt`=0, and that bit set gives length 5 and `out_fmt`=1.
- R3: Opcode 0x00, the no-operation, is 1 byte long whatever the ninth bit is, and reports `out_fmt`=0.
- R4: Short jump 0x40 and short call 0x42 are 4 bytes, and long jump 0x41 and long call 0x43 are 6 bytes, whatever the ninth bit is.
- R5: Opcodes 0x48 to 0x4F (branch compared against zero) are 4 bytes, and opcodes 0x50 to 0x57 (branch compared against a second register) are 5 bytes, whatever the ninth bit is.
- R6: Opcodes 0xF0 to 0xFF are unrecognised. They give `out_len`=1 and `out_illegal`=1.
- R7: A write with `tbl_we` stores `tbl_data` at `tbl_addr`, and decodes see it from the next cycle on. A decode in the cycle of the write still sees the old entry. A stored 0 means unrecognised.
- R8: While `run` is high and the instruction fits, `out_valid`=1 and `out_start` equals the offset. The offset then advances by `out_len` on the next edge.
- R9: If offset + length exceeds `buf_len`, `out_stall`=1 and `out_valid`=0, and the offset is held.
- R10: `restart` sets the offset to 0 on the next edge, and takes priority over an advance.
- R11: If the opcode is the last valid byte, the ninth bit is read as 0.
- R12: Return 0x44 is 4 bytes and return with stack update 0x45 is 5 bytes, whatever the ninth bit is.
- R13: While `run` is low, `out_valid` and `out_stall` are both 0 and the offset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Enable walking |
| restart | input | 1 | Return offset to zero |
| buf_data | input | BUF_BYTES*8 | Buffer bytes, byte i at bits 8i+7:8i |
| buf_len | input | PW | Count of valid buffer bytes |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 9 | Table write index |
| tbl_data | input | 3 | Length to store, 0 = unrecognised |
| out_valid | output | 1 | Instruction emitted this cycle |
| out_start | output | PW | Offset of the instruction |
| out_len | output | 3 | Decoded length in bytes |
| out_fmt | output | 1 | Format byte present |
| out_illegal | output | 1 | Unrecognised opcode |
| out_stall | output | 1 | Instruction does not fit in the valid bytes |

## Verification
A table write and a decode of the same entry can fall in the same cycle. The bench parks the walker on an ordinary opcode, then writes a new length to that opcode's entry. It checks that the length seen during the write is still the old one, and that the new length appears after the edge. A stall and a restart can also coincide. The bench drives `restart` while the walker is stalled at the end of the buffer, then checks that the next emitted start is offset 0.

// File: rtl/ilen_walker.sv
module ilen_walker #(
  parameter int BUF_BYTES = 32,
  localparam int PW = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   restart,
  input  logic [BUF_BYTES*8-1:0] buf_data,
  input  logic [PW-1:0]          buf_len,
  input  logic                   tbl_we,
  input  logic [8:0]             tbl_addr,
  input  logic [2:0]             tbl_data,
  output logic                   out_valid,
  output logic [PW-1:0]          out_start,
  output logic [2:0]             out_len,
  output logic                   out_fmt,
  output logic                   out_illegal,
  output logic                   out_stall
);

  function automatic logic [2:0] dflt(input logic [8:0] a);
    logic [7:0] op;
    op = a[7:0];
    if (op == 8'h00) return 3'd1;
    if (op >= 8'hF0) return 3'd0;
    if (op == 8'h40 || op == 8'h42 || op == 8'h44) return 3'd4;
    if (op == 8'h41 || op == 8'h43) return 3'd6;
    if (op == 8'h45) return 3'd5;
    if (op >= 8'h48 && op <= 8'h4F) return 3'd4;
    if (op >= 8'h50 && op <= 8'h57) return 3'd5;
    return a[8] ? 3'd5 : 3'd4;
  endfunction

  logic [2:0]    tbl [512];
  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) tbl[i] <= dflt(9'(i));
    end else if (tbl_we) begin
      tbl[tbl_addr] <= tbl_data;
    end
  end

  logic          have1, ninth;
  logic [PW-1:0] p0, p1;
  logic [7:0]    byte0, byte1;
  logic [2:0]    ent;
  logic [PW:0]   endp;

  assign have1 = ({1'b0, pos} + (PW+1)'(1)) < {1'b0, buf_len};
  assign p0    = (pos < PW'(BUF_BYTES)) ? pos : '0;
  assign p1    = have1 ? pos + PW'(1) : '0;
  assign byte0 = buf_data[{p0, 3'b000} +: 8];
  assign byte1 = buf_data[{p1, 3'b000} +: 8];
  assign ninth = have1 & byte1[0];
  assign ent   = tbl[{ninth, byte0}];

  assign out_illegal = (ent == 3'd0);
  assign out_len     = out_illegal ? 3'd1 : ent;
  assign out_fmt     = ninth & (ent > 3'd1);
  assign out_start   = pos;
  assign endp        = {1'b0, pos} + (PW+1)'(out_len);
  assign out_valid   = run & (endp <= {1'b0, buf_len});
  assign out_stall   = run & ~(endp <= {1'b0, buf_len});

  always_ff @(posedge clk) begin
    if (!rst_n)         pos <= '0;
    else if (restart)   pos <= '0;
    else if (out_valid) pos <= pos + PW'(out_len);
  end

endmodule

// File: rtl/ilen_walker_chk.sv
module ilen_walker_chk #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          restart,
  input logic [PW-1:0] buf_len,
  input logic [PW-1:0] pos,
  input logic          out_valid,
  input logic [PW-1:0] out_start,
  input logic [2:0]    out_len,
  input logic          out_fmt,
  input logic          out_illegal,
  input logic          out_stall
);

  p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len != 3'd0);

  p_fmt_multi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_fmt |-> out_len > 3'd1);

  p_illegal_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_len == 3'd1);

  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !restart) |=> pos == $past(pos) + PW'($past(out_len)));

  p_fit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_start} + (PW+1)'(out_len)) <= {1'b0, buf_len});

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stall && !restart) |=> $stable(pos));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pos == '0);

  p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !out_valid && !out_stall);

endmodule

bind ilen_walker ilen_walker_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .buf_len(buf_len),
  .pos(pos), .out_valid(out_valid), .out_start(out_start), .out_len(out_len),
  .out_fmt(out_fmt), .out_illegal(out_illegal), .out_stall(out_stall)
);

// File: tb/sim_ilen_walker.sv
`timescale 1ns/1ps
module sim_ilen_walker;
  localparam int NB = 32;
  localparam int PW = $clog2(NB + 1);

  logic clk = 0, rst_n = 0, run = 0, restart = 0, tbl_we = 0;
  logic [NB*8-1:0] buf_data;
  logic [PW-1:0] buf_len = '0;
  logic [8:0] tbl_addr = '0;
  logic [2:0] tbl_data = '0;
  logic out_valid, out_fmt, out_illegal, out_stall;
  logic [PW-1:0] out_start;
  logic [2:0] out_len;
  logic [7:0] mem [NB];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  always_comb for (int i = 0; i < NB; i++) buf_data[i*8 +: 8] = mem[i];

  ilen_walker #(.BUF_BYTES(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .buf_data(buf_data),
    .buf_len(buf_len), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .out_valid(out_valid), .out_start(out_start), .out_len(out_len),
    .out_fmt(out_fmt), .out_illegal(out_illegal), .out_stall(out_stall));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_ent(input int op, input int nb);
    if (op == 0) return 1;
    if (op >= 240) return 0;
    if (op == 64 || op == 66) return 4;
    if (op == 65 || op == 67) return 6;
    if (op == 68) return 4;
    if (op == 69) return 5;
    if (op >= 72 && op <= 79) return 4;
    if (op >= 80 && op <= 87) return 5;
    return nb ? 5 : 4;
  endfunction

  function automatic string tag(input int op);
    if (op == 0) return "R3";
    if (op >= 240) return "R6";
    if (op >= 64 && op <= 67) return "R4";
    if (op == 68 || op == 69) return "R12";
    if (op >= 72 && op <= 87) return "R5";
    return "R2";
  endfunction

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  task automatic pulse_restart;
    @(negedge clk); restart = 1; run = 0;
    @(negedge clk); restart = 0;
  endtask

  initial begin
    int exp_pos, e, l, nb;
    for (int i = 0; i < NB; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 start", out_start, 0);
    chk("R1 valid", out_valid, 0);
    chk("R13 stall idle", out_stall, 0);

    // sweep all nine-bit indices at offset 0
    buf_len = PW'(NB);
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      mem[0] = 8'(a % 256);
      mem[1] = {7'b0, 1'(a / 256)};
      #1;
      e = ref_ent(a % 256, a / 256);
      chk({tag(a % 256), " len"}, out_len, (e == 0) ? 1 : e);
      chk({tag(a % 256), " illegal"}, out_illegal, (e == 0) ? 1 : 0);
      chk({tag(a % 256), " fmt"}, out_fmt, ((a / 256) == 1 && e > 1) ? 1 : 0);
    end

    // R11: opcode is last valid byte
    @(negedge clk);
    mem[0] = 8'h10; mem[1] = 8'h01; buf_len = PW'(1); run = 1;
    #1;
    chk("R11 len", out_len, 4);
    chk("R11 fmt", out_fmt, 0);
    chk("R9 stall short", out_stall, 1);
    @(negedge clk);
    buf_len = PW'(2);
    #1;
    chk("R2 len fmt", out_len, 5);
    chk("R2 fmt", out_fmt, 1);
    chk("R9 start held", out_start, 0);
    run = 0;

    // walk a mixed stream
    for (int i = 0; i < NB; i++) mem[i] = 8'hAA;
    mem[0] = 8'h00;
    mem[1] = 8'h10; mem[2] = 8'h00;
    mem[5] = 8'h10; mem[6] = 8'h01;
    mem[10] = 8'h41; mem[11] = 8'h01;
    mem[16] = 8'hF3;
    mem[17] = 8'h50; mem[18] = 8'h00;
    mem[22] = 8'h44; mem[23] = 8'h01;
    mem[26] = 8'h10; mem[27] = 8'h00;
    buf_len = PW'(28);
    pulse_restart();
    run = 1;
    exp_pos = 0;
    for (int k = 0; k < 20; k++) begin
      #1;
      nb = (exp_pos + 1 < 28) ? int'(mem[exp_pos + 1][0]) : 0;
      e = ref_ent(int'(mem[exp_pos]), nb);
      l = (e == 0) ? 1 : e;
      if (exp_pos + l <= 28) begin
        chk("R8 valid", out_valid, 1);
        chk("R8 start", out_start, exp_pos);
        chk("R8 len", out_len, l);
        exp_pos += l;
        @(negedge clk);
      end else begin
        chk("R9 stall", out_stall, 1);
        chk("R9 valid", out_valid, 0);
        break;
      end
    end
    chk("R8 reached end", exp_pos, 26);
    @(negedge clk);
    #1;
    chk("R9 held", out_start, 26);

    // R13: run low holds
    @(negedge clk); run = 0; buf_len = PW'(NB);
    #1;
    chk("R13 valid", out_valid, 0);
    chk("R13 stall", out_stall, 0);
    @(negedge clk);
    #1;
    chk("R13 held", out_start, 26);

    // R10: restart while stalled and run high
    buf_len = PW'(28);
    run = 1;
    restart = 1;
    #1;
    chk("R9 stall before restart", out_stall, 1);
    @(negedge clk); restart = 0;
    #1;
    chk("R10 start", out_start, 0);
    chk("R10 valid", out_valid, 1);
    // R10 priority over advance
    restart = 1;
    @(negedge clk); restart = 0;
    #1;
    chk("R10 priority", out_start, 0);
    run = 0;

    // R7: table write with same-cycle decode
    @(negedge clk);
    mem[0] = 8'h10; mem[1] = 8'h00;
    tbl_we = 1; tbl_addr = 9'h010; tbl_data = 3'd7;
    #1;
    chk("R7 old entry", out_len, 4);
    @(negedge clk); tbl_we = 0;
    #1;
    chk("R7 new entry", out_len, 7);
    chk("R7 not illegal", out_illegal, 0);
    tbl_we = 1; tbl_data = 3'd0;
    @(negedge clk); tbl_we = 0;
    #1;
    chk("R7 illegal len", out_len, 1);
    chk("R7 illegal flag", out_illegal, 1);
    mem[1] = 8'h01;
    #1;
    chk("R7 other entry intact", out_len, 5);

    summary();
  end
endmodule